// File: doc/BRIEF.md
# Rewindable FIFO Read Controller

This block is the read side of a single-clock synchronous FIFO, with a small storage array and write pointer so that it can stand alone. Besides ordinary reads into a registered output, it accepts a rewind request that sends the read pointer back to storage location zero. Everything written since master reset can then be read out again, and the rewind can be repeated as many times as needed. The write pointer is never touched by a rewind, so the empty status after a rewind reflects the whole replayable contents.

The rewind latency is chosen once, while master reset is held. In normal mode the rewind edge only moves the pointer, and the first replayed word arrives on the next read. In zero-latency mode the first stored word is loaded into the output register on the same edge that samples the rewind request. Replay is meaningful while no more than DEPTH words have been written since master reset, so that location zero still holds the first word.

Top module: `rewind_fifo`

## Requirements
- R1: While `mrst` is high on a rising edge, the read pointer, write pointer and `rd_data` clear to zero. After release `empty` is 1 and `rd_data` is 0.
- R2: A `wr_en` edge while the FIFO is not full (fewer than DEPTH unread words) stores `wr_data`. `empty` is 0 after that edge.
- R3: A `rd_en` edge with `rewind_n` high and the FIFO not empty loads the oldest unread word into `rd_data`, in write order. With the FIFO empty, `rd_en` leaves `rd_data` unchanged and `empty` at 1.
- R4: `rewind_n` low on a rising edge sets the read pointer to location 0 and leaves the write pointer unchanged.
- R5: `latency_pick` is sampled only while `mrst` is high: 0 selects zero-latency mode and 1 selects normal mode. Changes after release have no effect.
- R6: In zero-latency mode, when at least one word has been stored since reset, the rewind edge loads word 0 into `rd_data` and the next read returns word 1. When nothing is stored, `rd_data` is unchanged.
- R7: In normal mode, the rewind edge leaves `rd_data` unchanged, and the next enabled read returns word 0.
- R8: `rd_en` is ignored on any edge where `rewind_n` is low.
- R9: Rewinds may be repeated, and each one replays the stored words from word 0 again.
- R10: After a rewind, `empty` is 1 exactly when the read pointer equals the write pointer. In normal mode with N>0 words stored it is 0. In zero-latency mode with one word stored it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mrst | input | 1 | Synchronous master reset, active high |
| latency_pick | input | 1 | Rewind latency choice sampled during reset (0 = zero latency, 1 = normal) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rewind_n | input | 1 | Rewind request, active low |
| rd_data | output | WIDTH | Registered output word |
| empty | output | 1 | No unread words |

## Verification
On every cycle the assertions check several properties. A normal-mode rewind holds the output and zeroes the pointer. A zero-latency rewind loads the word that was at location zero. The latched mode only changes across a reset edge, and the unread count never exceeds the depth. Which words come out in which order, the effect of reads when empty or during a rewind, and the value of `empty` after each rewind are shown only by the bench's scenarios against its reference model. This includes repeated replays in both modes.

// File: rtl/rewind_fifo_pkg.sv
package rewind_fifo_pkg;
    typedef enum logic {
        LAT_NORMAL = 1'b0,
        LAT_ZERO   = 1'b1
    } lat_mode_e;
endpackage

// File: rtl/rewind_store.sv
module rewind_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_word,
    output logic [WIDTH-1:0] head_word,
    output logic [PW-1:0]    wr_ptr
);
    typedef struct packed {
        logic [PW-1:0] wr_ptr;
    } wstate_t;

    wstate_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic full, accept;

    // Unread count equal to depth means no room.
    assign full   = (PW'(st_q.wr_ptr - rd_ptr) == PW'(DEPTH));
    assign accept = wr_en && !full && !mrst;

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d.wr_ptr = '0;
        end else if (accept) begin
            st_d.wr_ptr = st_q.wr_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            mem_q[st_q.wr_ptr[AW-1:0]] <= wr_data;
        end
    end

    assign rd_word   = mem_q[rd_ptr[AW-1:0]];
    assign head_word = mem_q[0];
    assign wr_ptr    = st_q.wr_ptr;

    AST_FULL_HOLDS_WPTR: assert property (@(posedge clk) disable iff (mrst)
        (full && wr_en) |=> (st_q.wr_ptr == $past(st_q.wr_ptr))); // R2
endmodule

// File: rtl/rewind_rd_ctrl.sv
module rewind_rd_ctrl
    import rewind_fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             latency_pick,
    input  logic             rd_en,
    input  logic             rewind_n,
    input  logic [PW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] rd_word,
    input  logic [WIDTH-1:0] head_word,
    output logic [PW-1:0]    rd_ptr,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);
    typedef struct packed {
        logic [PW-1:0]    rd_ptr;
        logic [WIDTH-1:0] dout;
        lat_mode_e        mode;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    is_empty;
    logic    has_stored;

    assign is_empty   = (st_q.rd_ptr == wr_ptr);
    assign has_stored = (wr_ptr != '0);

    always_comb begin
        st_d = st_q;
        if (mrst) begin
            st_d.rd_ptr = '0;
            st_d.dout   = '0;
            st_d.mode   = latency_pick ? LAT_NORMAL : LAT_ZERO;
        end else if (!rewind_n) begin
            if (st_q.mode == LAT_ZERO && has_stored) begin
                st_d.dout   = head_word;
                st_d.rd_ptr = PW'(1);
            end else begin
                st_d.rd_ptr = '0;
            end
        end else if (rd_en && !is_empty) begin
            st_d.dout   = rd_word;
            st_d.rd_ptr = st_q.rd_ptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_ptr  = st_q.rd_ptr;
    assign rd_data = st_q.dout;
    assign empty   = is_empty;

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (mrst)
        $past(mrst) |-> (rd_data == '0 && st_q.rd_ptr == '0)); // R1
    AST_NO_OVERREAD: assert property (@(posedge clk) disable iff (mrst)
        (PW'(wr_ptr - st_q.rd_ptr) <= PW'(DEPTH))); // R3
    AST_REWIND_TO_ZERO: assert property (@(posedge clk) disable iff (mrst)
        (!rewind_n && st_q.mode == LAT_NORMAL) |=> (st_q.rd_ptr == '0)); // R4
    AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (mrst)
        !$past(mrst) |-> $stable(st_q.mode)); // R5
    AST_ZERO_LAT_LOAD: assert property (@(posedge clk) disable iff (mrst)
        (!rewind_n && st_q.mode == LAT_ZERO && wr_ptr != '0)
        |=> (rd_data == $past(head_word) && st_q.rd_ptr == PW'(1))); // R6
    AST_NORMAL_HOLD: assert property (@(posedge clk) disable iff (mrst)
        (!rewind_n && st_q.mode == LAT_NORMAL) |=> $stable(rd_data)); // R7
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             latency_pick,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             rewind_n,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0]    wr_ptr;
    logic [PW-1:0]    rd_ptr;
    logic [WIDTH-1:0] rd_word;
    logic [WIDTH-1:0] head_word;

    rewind_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .mrst      (mrst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_ptr    (rd_ptr),
        .rd_word   (rd_word),
        .head_word (head_word),
        .wr_ptr    (wr_ptr)
    );

    rewind_rd_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rd (
        .clk          (clk),
        .mrst         (mrst),
        .latency_pick (latency_pick),
        .rd_en        (rd_en),
        .rewind_n     (rewind_n),
        .wr_ptr       (wr_ptr),
        .rd_word      (rd_word),
        .head_word    (head_word),
        .rd_ptr       (rd_ptr),
        .rd_data      (rd_data),
        .empty        (empty)
    );
endmodule

// File: tb/rewind_fifo_test.sv
module rewind_fifo_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int D = 8;
    localparam int PM = 2 * D;

    logic clk = 1'b0;
    logic mrst = 1'b1;
    logic latency_pick = 1'b1;
    logic wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic rd_en = 1'b0;
    logic rewind_n = 1'b1;
    logic [W-1:0] rd_data;
    logic empty;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [W-1:0] m_mem [D];
    int m_wr, m_rd, m_writes;
    logic [W-1:0] m_out;
    bit m_zero;

    rewind_fifo #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .mrst(mrst), .latency_pick(latency_pick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rewind_n(rewind_n), .rd_data(rd_data), .empty(empty)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit m_empty();
        return m_rd == m_wr;
    endfunction

    function automatic int m_count();
        return (m_wr - m_rd + PM) % PM;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] got_d,
                         input logic [W-1:0] exp_d, input logic got_e, input logic exp_e);
        checks++;
        if (got_d !== exp_d || got_e !== exp_e) begin
            fails++;
            $display("FAIL %s: rd_data=%0h empty=%0b expected rd_data=%0h empty=%0b",
                     tag, got_d, got_e, exp_d, exp_e);
        end
    endtask

    task automatic do_reset(input bit lat);
        @(negedge clk);
        mrst = 1'b1; latency_pick = lat; wr_en = 0; rd_en = 0; rewind_n = 1;
        @(negedge clk);
        mrst = 1'b0;
        m_wr = 0; m_rd = 0; m_out = '0; m_zero = !lat; m_writes = 0;
        latency_pick = $urandom_range(0, 1);  // ignored after release (R5)
        @(posedge clk); #1;
        check("R1", rd_data, '0, empty, 1'b1);
    endtask

    // One clock: drive at negedge, advance the model, check after the edge.
    task automatic cyc(input string tag, input bit re, input bit rw_n,
                       input bit we, input logic [W-1:0] wd);
        bit full_now;
        @(negedge clk);
        rd_en = re; rewind_n = rw_n; wr_en = we; wr_data = wd;
        full_now = (m_count() == D);
        if (we && !full_now) begin
            m_mem[m_wr % D] = wd;
            m_writes++;
        end
        if (!rw_n) begin
            if (m_zero && m_wr != 0) begin
                m_out = m_mem[0];
                m_rd = 1;
            end else begin
                m_rd = 0;
            end
        end else if (re && !m_empty()) begin
            m_out = m_mem[m_rd % D];
            m_rd = (m_rd + 1) % PM;
        end
        if (we && !full_now) m_wr = (m_wr + 1) % PM;
        @(posedge clk); #1;
        check(tag, rd_data, m_out, empty, m_empty());
        rd_en = 0; rewind_n = 1; wr_en = 0;
    endtask

    initial begin
        int cycles = 0;
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: expired expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        // Normal-latency mode
        do_reset(1'b1);
        cyc("R3 empty read", 1, 1, 0, 0);
        for (int i = 0; i < 5; i++) cyc("R2", 0, 1, 1, W'(8'h10 + i));
        cyc("R3", 1, 1, 0, 0);
        cyc("R3", 1, 1, 0, 0);
        cyc("R7 hold on rewind", 0, 0, 0, 0);
        cyc("R10 normal not empty", 0, 1, 0, 0);
        cyc("R7 word0 after rewind", 1, 1, 0, 0);
        cyc("R8 read ignored during rewind", 1, 0, 0, 0);
        cyc("R4 word0 again", 1, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc("R3", 1, 1, 0, 0);
        cyc("R3 empty read", 1, 1, 0, 0);
        cyc("R9 second rewind", 0, 0, 0, 0);
        cyc("R9 replay", 1, 1, 0, 0);
        cyc("R5 mode kept", 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R2 fill", 0, 1, 1, W'(8'h20 + i));
        for (int i = 0; i < 2; i++) cyc("R2 full ignored", 0, 1, 1, 8'hEE);
        cyc("R4 wptr kept", 0, 0, 0, 0);
        for (int i = 0; i < 9; i++) cyc("R4 replay full", 1, 1, 0, 0);

        // Zero-latency mode
        do_reset(1'b0);
        cyc("R6 rewind with nothing stored", 0, 0, 0, 0);
        cyc("R2", 0, 1, 1, 8'hA5);
        cyc("R10 zero one word", 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R2", 0, 1, 1, W'(8'h30 + i));
        cyc("R3", 1, 1, 0, 0);
        cyc("R3", 1, 1, 0, 0);
        cyc("R6 same-edge load", 0, 0, 0, 0);
        cyc("R6 then word1", 1, 1, 0, 0);
        cyc("R9 repeat", 0, 0, 0, 0);
        cyc("R8 read ignored during rewind", 1, 0, 0, 0);
        cyc("R9 continue", 1, 1, 0, 0);

        // Random episodes, at most D writes each so replay stays valid
        for (int ep = 0; ep < 30; ep++) begin
            do_reset(1'($urandom_range(0, 1)));
            for (int c = 0; c < 50; c++) begin
                bit re, rw, we;
                re = ($urandom_range(0, 99) < 50);
                rw = !($urandom_range(0, 99) < 10);
                we = ($urandom_range(0, 99) < 40) && (m_writes < D);
                cyc(rw ? "R3 random" : "R4 random", re, rw, we, W'($urandom));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule